// File: doc/BRIEF.md
# Convolutional Interleaver Address Generator

This block generates the addresses for a convolutional interleaver whose symbols sit in one flat circular buffer rather than in one FIFO per branch. The external buffer is written in plain arrival order, so each incoming symbol goes to the next sequential location. The interleaving comes entirely from the read address. For each accepted symbol the block also reports which commutator branch the symbol belongs to. Each branch delays its symbols by a whole number of frames, so the read address is the write address moved back by that delay, taken modulo the buffer size.

The geometry is set by parameters. `BRANCHES` is the number of commutator positions, and `UNIT` is the per-branch delay step in symbols. A symbol on branch i leaves i × UNIT × BRANCHES symbol periods after it arrives. `DEPTH` is the buffer size. Its default is the smallest safe value, (BRANCHES−1) × UNIT × BRANCHES + 1, which is 312001 entries for 40 branches and a step of 200. At that size, the write pointer cannot come back round to a location before the longest-delayed symbol stored there has been read.

All outputs are combinational from the internal state and refer to the symbol currently offered on `sym_valid`. The buffer writes the symbol at `wr_addr` and, in the same access, returns the entry at `rd_addr`. When the two addresses are equal (branch 0), the buffer must pass the new symbol straight through.

Top module: `cil_addr_gen`

## Requirements
- R1: After reset, `wr_addr` is 0, `branch` is 0 and `out_valid` is low.
- R2: Each cycle with `sym_valid` high advances `wr_addr` by one. After DEPTH−1 it returns to 0.
- R3: Each cycle with `sym_valid` high advances `branch` by one. After BRANCHES−1 it returns to 0.
- R4: While `sym_valid` is high, `rd_addr` equals (`wr_addr` − `branch` × UNIT × BRANCHES) modulo DEPTH, and it is always below DEPTH.
- R5: On branch 0, `rd_addr` equals `wr_addr`, and `out_valid` is high whenever `sym_valid` is high.
- R6: `out_valid` is high only when `sym_valid` is high and at least `branch` × UNIT × BRANCHES symbols have been accepted since reset.
- R7: A cycle with `sym_valid` low changes neither `wr_addr` nor `branch`, and it does not count as an accepted symbol.
- R8: DEPTH must be at least (BRANCHES−1) × UNIT × BRANCHES + 1. With such a DEPTH, the entry read for every symbol that has `out_valid` set is the symbol accepted exactly `branch` × UNIT × BRANCHES symbols before it on the same branch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_valid | input | 1 | A symbol is offered this cycle |
| wr_addr | output | $clog2(DEPTH) | Buffer address where the current symbol is written |
| rd_addr | output | $clog2(DEPTH) | Buffer address of the delayed symbol to read |
| branch | output | $clog2(BRANCHES) | Commutator branch of the current symbol |
| out_valid | output | 1 | The read entry holds a real symbol, not fill-time garbage |

## Verification
Every cycle, the assertions check the following:
- the sequential stepping and wrap of the write pointer and the branch counter;
- that both hold on idle cycles;
- the bounds on the read address;
- the branch-0 pass-through;
- that `out_valid` is low when no symbol is offered.

The bench scenarios are needed for the properties that span many symbols:
- the exact modular read address;
- the fill-time gating of `out_valid` per branch;
- that the data read back from a model buffer of the minimum size equals the symbol accepted exactly one branch delay earlier, across several buffer wraps and with idle gaps.

// File: rtl/cil_addr_gen.sv
module cil_addr_gen #(
  parameter int BRANCHES = 40,
  parameter int UNIT     = 200,
  parameter int DEPTH    = (BRANCHES - 1) * UNIT * BRANCHES + 1,
  localparam int STEP    = UNIT * BRANCHES,
  localparam int MAXDLY  = (BRANCHES - 1) * STEP,
  localparam int AW      = $clog2(DEPTH),
  localparam int BW      = (BRANCHES > 1) ? $clog2(BRANCHES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sym_valid,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic [BW-1:0] branch,
  output logic          out_valid
);

  logic [AW-1:0] wptr;
  logic [AW-1:0] dly;
  logic [AW-1:0] fill;
  logic [BW-1:0] br;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      br   <= '0;
      dly  <= '0;
      fill <= '0;
    end else if (sym_valid) begin
      wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (br == BW'(BRANCHES - 1)) begin
        br  <= '0;
        dly <= '0;
      end else begin
        br  <= br + 1'b1;
        dly <= dly + AW'(STEP);
      end
      if (fill != AW'(MAXDLY))
        fill <= fill + 1'b1;
    end
  end

  assign wr_addr   = wptr;
  assign branch    = br;
  assign rd_addr   = (wptr >= dly) ? wptr - dly : wptr + AW'(DEPTH) - dly;
  assign out_valid = sym_valid && (fill >= dly);

  initial begin
    AST_DEPTH_MIN: assert (DEPTH >= MAXDLY + 1); // R8
  end

  AST_WR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid |=> wr_addr == (($past(wr_addr) == AW'(DEPTH - 1)) ? '0 : $past(wr_addr) + 1'b1)); // R2
  AST_BR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid |=> branch == (($past(branch) == BW'(BRANCHES - 1)) ? '0 : $past(branch) + 1'b1)); // R3
  AST_RD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_addr < AW'(DEPTH)); // R4
  AST_BR0_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && branch == '0) |-> (out_valid && rd_addr == wr_addr)); // R5
  AST_IDLE_NOVALID: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_valid |-> !out_valid); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_valid |=> ($stable(wr_addr) && $stable(branch))); // R7

endmodule

// File: tb/sim_cil_addr_gen.sv
module sim_cil_addr_gen;
  localparam int B  = 4;
  localparam int M  = 2;
  localparam int D  = (B - 1) * M * B + 1;
  localparam int AW = $clog2(D);
  localparam int BW = $clog2(B);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sym_valid = 1'b0;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [BW-1:0] branch;
  logic out_valid;

  int checks = 0;
  int failures = 0;
  int mem [D];

  always #5 clk = ~clk;

  cil_addr_gen #(.BRANCHES(B), .UNIT(M), .DEPTH(D)) u0 (
    .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid),
    .wr_addr(wr_addr), .rd_addr(rd_addr), .branch(branch), .out_valid(out_valid));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin : watchdog
    #1000000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n;
    int dly;
    int rdata;
    for (int i = 0; i < D; i++) mem[i] = -1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 wr_addr", int'(wr_addr), 0);
    chk("R1 branch", int'(branch), 0);
    chk("R1 out_valid", int'(out_valid), 0);
    n = 0;
    for (int cyc = 0; cyc < 6 * D; cyc++) begin
      @(negedge clk);
      sym_valid = !((cyc % 7 == 3) || (cyc % 11 == 5));
      #1;
      if (sym_valid) begin
        dly = (n % B) * M * B;
        chk("R2 wr_addr", int'(wr_addr), n % D);
        chk("R3 branch", int'(branch), n % B);
        chk("R4 rd_addr", int'(rd_addr), ((n % D) + D - dly) % D);
        chk("R6 out_valid", int'(out_valid), (n >= dly) ? 1 : 0);
        if (n % B == 0) chk("R5 rd_eq_wr", int'(rd_addr == wr_addr), 1);
        rdata = (rd_addr == wr_addr) ? n : mem[rd_addr];
        if (out_valid) chk("R8 read_data", rdata, n - dly);
        mem[wr_addr] = n;
        n++;
      end else begin
        chk("R7 wr_addr_hold", int'(wr_addr), n % D);
        chk("R7 branch_hold", int'(branch), n % B);
        chk("R6 idle_valid", int'(out_valid), 0);
      end
    end
    @(negedge clk);
    sym_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 wr_addr_rereset", int'(wr_addr), 0);
    chk("R1 branch_rereset", int'(branch), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule